// File: doc/BRIEF.md
# PWM Output Steering Unit

This block takes a single pulse-width-modulated waveform and distributes it to any subset of four output pins at once. Each pin has its own steering enable; a pin that is not steered shows its general-purpose port data bit, so every pin sits behind a 2:1 selector between the modulated waveform and port data. A two-bit polarity field makes the steered pins active-high or active-low in two pairs, and a shutdown input forces only the steered pins to their inactive level.

A single configuration word is written through a one-cycle write port. Its sync bit decides when the new set of enables takes hold: at once on the cycle after the write, possibly cutting a pulse short, or deferred to the next period-start strobe from the PWM generator, so that every steered pulse is whole. Steering applies only while the generator is in single-output mode; in any other mode all pins show port data.

Top module: `pwm_steer`

## Requirements
- R1: Reset clears all four steering enables and the pending value and sets both polarity bits to active-high, so after reset every pin shows its port data bit.
- R2: A pin whose effective enable is clear drives its port data bit; with all enables clear all four pins show port data.
- R3: A pin whose effective enable is set drives the PWM signal, and any subset of the four pins (A..D on bits 0..3) can be driven at the same time.
- R4: Configuration bit 5 inverts pins A and C, bit 4 inverts pins B and D; a set bit makes the pin active-low. Unsteered pins are never inverted.
- R5: A write with bit 6 (sync) at 0 loads enables from bits 3:0 on the cycle after the write, at any point in the period, and discards any pending value.
- R6: A write with sync at 1 holds bits 3:0 pending and leaves the pins unchanged; on the next period-start strobe the pending enables drive the pins in the strobe cycle itself and become active afterwards.
- R7: When a write coincides with a strobe, the older pending value still applies in that strobe cycle; the write then acts as in R5 or R6 from the following cycle.
- R8: While shutdown is high, each steered pin drives its inactive level (0 when active-high, 1 when active-low); unsteered pins keep port data.
- R9: After shutdown falls, steered pins stay at the inactive level until a period-start strobe arrives with shutdown low; output resumes in that strobe cycle.
- R10: When the single-output mode input is low, all four pins show port data, and the stored enables are kept for when the mode returns.
- R11: A polarity change written by any write takes effect on the cycle after the write, regardless of the sync bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| single_mode | input | 1 | High while the PWM generator runs in single-output mode |
| pwm_in | input | 1 | Modulated waveform to be steered |
| period_start | input | 1 | One-cycle strobe in the first cycle of each PWM period |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration word: enables [3:0], polarity [5:4], sync [6] |
| port_data | input | 4 | Port data bits shown by unsteered pins |
| shutdown | input | 1 | Fault input forcing steered pins inactive |
| pin_out | output | 4 | Pin levels A..D on bits 0..3 |

## Verification
The assertions assume that period_start is a clean one-cycle strobe that the generator raises in the first cycle of a period, and that cfg_we is a one-cycle pulse whose data is valid in the same cycle; shutdown and port data may change on any cycle. The stimulus keeps to this by driving strobes on a fixed stride or as single directed pulses, and by writing only for a single cycle, while letting shutdown, the mode input, port data and the waveform move freely, including writes that land on a strobe cycle and shutdown releases between strobes.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

  // Polarity bit for a pin: even pins (A, C) follow the upper bit,
  // odd pins (B, D) follow the lower bit.
  function automatic logic pol_for_pin(input int unsigned idx, input logic [1:0] pol);
    return idx[0] ? pol[0] : pol[1];
  endfunction

  // Level on one pin given its selector, waveform, inversion and force.
  function automatic logic drive_pin(input logic steer, input logic pwm,
                                     input logic inv, input logic force_off,
                                     input logic port);
    return steer ? ((pwm & ~force_off) ^ inv) : port;
  endfunction

endpackage

// File: rtl/steer_cfg_regs.sv
module steer_cfg_regs #(
  parameter int NUM_PINS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [NUM_PINS+2:0]   cfg_wdata,
  input  logic                  period_start,
  output logic [NUM_PINS-1:0]   steer_eff,
  output logic [NUM_PINS-1:0]   steer_act,
  output logic [NUM_PINS-1:0]   steer_pend,
  output logic                  pend_valid,
  output logic [1:0]            pol_q
);
  localparam int POL_LO   = NUM_PINS;
  localparam int SYNC_BIT = NUM_PINS + 2;

  logic wr_sync;
  logic imm_write;
  logic pend_write;
  logic apply_pend;

  assign wr_sync    = cfg_wdata[SYNC_BIT];
  assign imm_write  = cfg_we & ~wr_sync;
  assign pend_write = cfg_we & wr_sync;
  assign apply_pend = period_start & pend_valid;

  // Pending value reaches the pins inside the strobe cycle itself.
  assign steer_eff = apply_pend ? steer_pend : steer_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      steer_act  <= '0;
      steer_pend <= '0;
      pend_valid <= 1'b0;
      pol_q      <= 2'b00;
    end else begin
      if (imm_write) begin
        steer_act <= cfg_wdata[NUM_PINS-1:0];
      end else if (apply_pend) begin
        steer_act <= steer_pend;
      end

      if (pend_write) begin
        steer_pend <= cfg_wdata[NUM_PINS-1:0];
        pend_valid <= 1'b1;
      end else if (imm_write || apply_pend) begin
        pend_valid <= 1'b0;
      end

      if (cfg_we) begin
        pol_q <= cfg_wdata[POL_LO+1:POL_LO];
      end
    end
  end

endmodule

// File: rtl/steer_shutdown_ctl.sv
module steer_shutdown_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic shutdown,
  input  logic period_start,
  output logic force_off
);
  logic sd_held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sd_held <= 1'b0;
    end else if (shutdown) begin
      sd_held <= 1'b1;
    end else if (period_start) begin
      sd_held <= 1'b0;
    end
  end

  // Release lands on the strobe cycle so the new period is whole.
  assign force_off = shutdown | (sd_held & ~period_start);

endmodule

// File: rtl/steer_pin_mux.sv
module steer_pin_mux #(
  parameter int NUM_PINS = 4
) (
  input  logic [NUM_PINS-1:0] steer_mask,
  input  logic                pwm_in,
  input  logic [1:0]          pol_q,
  input  logic                force_off,
  input  logic [NUM_PINS-1:0] port_data,
  output logic [NUM_PINS-1:0] pin_out
);
  import pwm_steer_pkg::*;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic inv;
    assign inv        = pol_for_pin(i, pol_q);
    assign pin_out[i] = drive_pin(steer_mask[i], pwm_in, inv, force_off, port_data[i]);
  end

endmodule

// File: rtl/pwm_steer.sv
module pwm_steer #(
  parameter int NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                single_mode,
  input  logic                pwm_in,
  input  logic                period_start,
  input  logic                cfg_we,
  input  logic [NUM_PINS+2:0] cfg_wdata,
  input  logic [NUM_PINS-1:0] port_data,
  input  logic                shutdown,
  output logic [NUM_PINS-1:0] pin_out
);
  logic [NUM_PINS-1:0] steer_eff;
  logic [NUM_PINS-1:0] steer_act;
  logic [NUM_PINS-1:0] steer_pend;
  logic [NUM_PINS-1:0] steer_mask;
  logic                pend_valid;
  logic [1:0]          pol_q;
  logic                force_off;

  steer_cfg_regs #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .period_start (period_start),
    .steer_eff    (steer_eff),
    .steer_act    (steer_act),
    .steer_pend   (steer_pend),
    .pend_valid   (pend_valid),
    .pol_q        (pol_q)
  );

  steer_shutdown_ctl u_sd (
    .clk          (clk),
    .rst_n        (rst_n),
    .shutdown     (shutdown),
    .period_start (period_start),
    .force_off    (force_off)
  );

  assign steer_mask = single_mode ? steer_eff : '0;

  steer_pin_mux #(.NUM_PINS(NUM_PINS)) u_mux (
    .steer_mask (steer_mask),
    .pwm_in     (pwm_in),
    .pol_q      (pol_q),
    .force_off  (force_off),
    .port_data  (port_data),
    .pin_out    (pin_out)
  );

endmodule

// File: rtl/pwm_steer_chk.sv
module pwm_steer_chk #(
  parameter int NUM_PINS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                single_mode,
  input logic                pwm_in,
  input logic                period_start,
  input logic                cfg_we,
  input logic [NUM_PINS+2:0] cfg_wdata,
  input logic [NUM_PINS-1:0] port_data,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] steer_mask,
  input logic [NUM_PINS-1:0] steer_act,
  input logic [NUM_PINS-1:0] steer_pend,
  input logic                pend_valid,
  input logic [1:0]          pol_q,
  input logic                force_off
);
  localparam int SYNC_BIT = NUM_PINS + 2;

  logic [NUM_PINS-1:0] inv_mask;
  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      inv_mask[i] = (i % 2 == 1) ? pol_q[0] : pol_q[1];
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (steer_act == '0 && !pend_valid && pol_q == 2'b00)); // R1

  AST_UNSTEERED_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out ^ port_data) & ~steer_mask) == '0); // R2

  AST_STEERED_WAVE: assert property (@(posedge clk) disable iff (!rst_n)
    !force_off |-> ((pin_out ^ ({NUM_PINS{pwm_in}} ^ inv_mask)) & steer_mask) == '0); // R4

  AST_IMM_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_wdata[SYNC_BIT]) |=>
      (steer_act == $past(cfg_wdata[NUM_PINS-1:0]) && !pend_valid)); // R5

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[SYNC_BIT] && !(period_start && pend_valid)) |=>
      ($stable(steer_act) && pend_valid)); // R6

  AST_STROBE_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && pend_valid && !cfg_we) |=>
      (steer_act == $past(steer_pend) && !pend_valid)); // R6

  AST_SD_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |-> ((pin_out ^ inv_mask) & steer_mask) == '0); // R8

  AST_RESUME_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(force_off) |-> period_start); // R9

  AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !single_mode |-> (pin_out == port_data)); // R10

endmodule

bind pwm_steer pwm_steer_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .single_mode  (single_mode),
  .pwm_in       (pwm_in),
  .period_start (period_start),
  .cfg_we       (cfg_we),
  .cfg_wdata    (cfg_wdata),
  .port_data    (port_data),
  .pin_out      (pin_out),
  .steer_mask   (steer_mask),
  .steer_act    (steer_act),
  .steer_pend   (steer_pend),
  .pend_valid   (pend_valid),
  .pol_q        (pol_q),
  .force_off    (force_off)
);

// File: tb/pwm_steer_tb.sv
`timescale 1ns/1ps
module pwm_steer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       single_mode = 1'b1;
  logic       pwm_in = 1'b0;
  logic       period_start = 1'b0;
  logic       cfg_we = 1'b0;
  logic [6:0] cfg_wdata = 7'd0;
  logic [3:0] port_data = 4'd0;
  logic       shutdown = 1'b0;
  logic [3:0] pin_out;

  int checks = 0;
  int fails = 0;
  string cur_tag = "R1";

  always #4 clk = ~clk;

  pwm_steer u_dut (
    .clk(clk), .rst_n(rst_n), .single_mode(single_mode), .pwm_in(pwm_in),
    .period_start(period_start), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .port_data(port_data), .shutdown(shutdown), .pin_out(pin_out)
  );

  // Behavioural reference state
  bit [3:0] m_act, m_pend;
  bit       m_pv, m_held;
  bit [1:0] m_pol;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_pend = 0; m_pv = 0; m_held = 0; m_pol = 0;
    end else begin
      if (period_start && m_pv) begin m_act = m_pend; m_pv = 0; end
      if (cfg_we) begin
        m_pol = cfg_wdata[5:4];
        if (cfg_wdata[6]) begin m_pend = cfg_wdata[3:0]; m_pv = 1; end
        else begin m_act = cfg_wdata[3:0]; m_pv = 0; end
      end
      if (shutdown) m_held = 1;
      else if (period_start) m_held = 0;
    end
  end

  function automatic bit [3:0] expected();
    bit [3:0] sel, res;
    bit blocked;
    sel = (period_start && m_pv) ? m_pend : m_act;
    if (!single_mode) sel = 0;
    blocked = shutdown || (m_held && !period_start);
    for (int i = 0; i < 4; i++) begin
      bit lowact;
      lowact = (i == 0 || i == 2) ? m_pol[1] : m_pol[0];
      if (sel[i]) res[i] = (blocked ? 1'b0 : pwm_in) ^ lowact;
      else        res[i] = port_data[i];
    end
    return res;
  endfunction

  task automatic cyc();
    bit [3:0] exp_v;
    #2;
    exp_v = expected();
    checks++;
    if (pin_out !== exp_v) begin
      fails++;
      $display("FAIL %s: pin_out=%b expected=%b at %0t", cur_tag, pin_out, exp_v, $time);
    end
    @(negedge clk);
    pwm_in = ~pwm_in;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      port_data = 4'($urandom);
      cyc();
    end
  endtask

  task automatic wr(input bit [6:0] d);
    cfg_we = 1; cfg_wdata = d; cyc(); cfg_we = 0;
  endtask

  task automatic strobe();
    period_start = 1; cyc(); period_start = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    cur_tag = "R1 reset";
    idle(3);
    rst_n = 1;
    idle(3);

    cur_tag = "R2 no steering";
    port_data = 4'b1010; cyc();
    port_data = 4'b0101; cyc();
    idle(4);

    cur_tag = "R3/R5 immediate subsets";
    wr(7'b000_0101); idle(4);
    wr(7'b000_1111); idle(4);
    wr(7'b000_0010); idle(3);

    cur_tag = "R4/R11 polarity";
    wr(7'b010_1111); idle(4);
    wr(7'b001_1111); idle(4);
    wr(7'b011_0110); idle(3);
    wr(7'b000_1001); idle(2);

    cur_tag = "R6 pending until strobe";
    wr(7'b100_0011); idle(4);
    strobe(); idle(3);
    wr(7'b110_1100); idle(2);
    strobe(); idle(2);

    cur_tag = "R5 immediate drops pending";
    wr(7'b100_1111); wr(7'b000_0100); idle(2);
    strobe(); idle(2);

    cur_tag = "R7 write on strobe";
    wr(7'b100_1010);
    cfg_we = 1; cfg_wdata = 7'b000_0001; period_start = 1; cyc();
    cfg_we = 0; period_start = 0; idle(3);
    wr(7'b100_0110);
    cfg_we = 1; cfg_wdata = 7'b101_1001; period_start = 1; cyc();
    cfg_we = 0; period_start = 0; idle(3);
    strobe(); idle(2);

    cur_tag = "R8 shutdown";
    wr(7'b000_0110);
    shutdown = 1; idle(4);
    wr(7'b011_0110); idle(2);
    cur_tag = "R9 resume at strobe";
    shutdown = 0; idle(4);
    strobe(); idle(3);
    shutdown = 1; cyc(); shutdown = 0; idle(2);
    shutdown = 1; period_start = 1; cyc(); shutdown = 0; period_start = 0; idle(2);
    strobe(); idle(2);

    cur_tag = "R10 mode gate";
    wr(7'b000_1111);
    single_mode = 0; idle(5);
    single_mode = 1; idle(3);

    cur_tag = "R2-R11 mixed random";
    for (int n = 0; n < 4000; n++) begin
      port_data    = 4'($urandom);
      period_start = (n % 8 == 0);
      shutdown     = ($urandom % 23 == 0);
      single_mode  = ($urandom % 31 != 0);
      cfg_we       = ($urandom % 9 == 0);
      cfg_wdata    = 7'($urandom);
      pwm_in       = ($urandom % 3 != 0);
      cyc();
    end
    cfg_we = 0; period_start = 0; shutdown = 0;

    cur_tag = "R1 re-reset";
    rst_n = 0; idle(2); rst_n = 1; idle(2);

    summary();
    $finish;
  end

endmodule